// File: doc/BRIEF.md
# Downstream Port Power and Status Manager

This block sits beside the hub controller of a four-port full/low-speed USB hub and owns everything about the power of the downstream ports. It filters the per-port overcurrent sense lines, switches the port power enables, tracks whether each port is enabled (and drives a connect-status indicator from that), and keeps status and sticky change bits that the hub controller reads out and acknowledges. A strap selects bus-powered or self-powered operation. In self-powered operation the local supply status is tracked and a second strap can make port power unswitched.

The hub controller turns host port requests into single-cycle commands on `req_valid`/`req_op`/`req_port`. Two mode inputs choose ganged or per-port behaviour. One covers power switching, where a command or a fault acts on all ports. The other covers overcurrent reporting, where a fault on any port is reported on all of them. A 1 ms tick from the chip's timebase sets the overcurrent debounce window.

Top module: `hub_port_power`

## Requirements
- R1: After reset, `pwr_en`, `conn_stat`, `oc_stat`, `oc_chg`, `lp_stat` and `lp_chg` are all zero.
- R2: Each overcurrent input passes two synchronising flops. Its filtered state changes only after the synchronised level has differed from it on DEB_TICKS (default 8) consecutive `tick_ms` pulses. A shorter pulse changes no output.
- R3: While power is switched (not self-powered with `pwr_switched`=0), a port whose `oc_stat` bit is 1 has `pwr_en` 0 from the next cycle. Its power stays off after the fault clears until a set-power command (op 1). A set-power command given while `oc_stat` is 1 is refused.
- R4: `oc_chg[i]` is set on every change of `oc_stat[i]`. It stays set until a clear-overcurrent-change command (op 5) addresses port i. If a clear and a change happen in the same cycle, the bit stays set.
- R5: Op 3 enables a port and op 4 disables it. A port is only enabled while powered, and it is disabled when its power is removed. `conn_stat[i]` is 1 exactly while port i is enabled.
- R6: With `gang_ovc`=1, a filtered overcurrent on any port sets every `oc_stat` bit and removes power from every port.
- R7: With `gang_pwr`=1, set-power (op 1) and clear-power (op 2) act on all ports regardless of `req_port`, and an overcurrent on any port removes power from all ports. With `gang_pwr`=0, they act only on the port `req_port` names. Op codes 0 and 7 have no effect.
- R8: With `self_pwr`=1 and `pwr_switched`=0, all `pwr_en` bits are 1 from the next cycle, whatever the overcurrent state.
- R9: With `self_pwr`=1, `lp_stat` follows `local_good` through two synchronising flops plus one register. `lp_chg` is set on each change and cleared by op 6. With `self_pwr`=0, `lp_stat` reads 0 and `lp_chg` is not set by `local_good` activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| self_pwr | input | 1 | Power-mode strap: 1 self-powered, 0 bus-powered |
| pwr_switched | input | 1 | In self-powered mode, 1 switched power, 0 unswitched |
| gang_pwr | input | 1 | 1 ganged power switching, 0 per port |
| gang_ovc | input | 1 | 1 ganged overcurrent reporting, 0 per port |
| local_good | input | 1 | Local supply status, asynchronous |
| oc_in | input | NPORTS | Overcurrent sense per port, active high, asynchronous |
| req_valid | input | 1 | Command strobe |
| req_op | input | 3 | Command: 1 set power, 2 clear power, 3 enable, 4 disable, 5 clear overcurrent change, 6 clear local-power change |
| req_port | input | $clog2(NPORTS) | Port addressed by the command |
| pwr_en | output | NPORTS | Port power switch enables |
| conn_stat | output | NPORTS | Connect-status indicators (port enabled) |
| oc_stat | output | NPORTS | Filtered overcurrent status per port |
| oc_chg | output | NPORTS | Sticky overcurrent change bits |
| lp_stat | output | 1 | Local supply status (self-powered only) |
| lp_chg | output | 1 | Sticky local supply change bit |

## Verification
The hardest state to reach is a fault that is refused and then recovered. The filtered overcurrent must be held while a set-power command arrives, which must then be refused. After the fault clears, the change bit must still be set and the power still off. The stimulus holds `oc_in` for well over DEB_TICKS tick periods and issues set-power commands both during the fault and after its release. It also sends a pulse shorter than the window, which must have no effect. It repeats the fault under ganged reporting and ganged power, and a behavioural model compares every output on every clock.

// File: rtl/hub_port_power.sv
module hub_port_power #(
  parameter int NPORTS    = 4,
  parameter int DEB_TICKS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_ms,
  input  logic                      self_pwr,
  input  logic                      pwr_switched,
  input  logic                      gang_pwr,
  input  logic                      gang_ovc,
  input  logic                      local_good,
  input  logic [NPORTS-1:0]         oc_in,
  input  logic                      req_valid,
  input  logic [2:0]                req_op,
  input  logic [$clog2(NPORTS)-1:0] req_port,
  output logic [NPORTS-1:0]         pwr_en,
  output logic [NPORTS-1:0]         conn_stat,
  output logic [NPORTS-1:0]         oc_stat,
  output logic [NPORTS-1:0]         oc_chg,
  output logic                      lp_stat,
  output logic                      lp_chg
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [NPORTS-1:0] oc_s1, oc_s2, oc_flt, oc_prev;
  logic [NPORTS-1:0] sw_q, pwr_q, en_q, chg_q;
  logic lp_s1, lp_s2, lp_q, lpc_q;

  wire unsw = self_pwr & ~pwr_switched;
  wire cmd_set_pwr = req_valid && req_op == 3'd1;
  wire cmd_clr_pwr = req_valid && req_op == 3'd2;
  wire cmd_set_en  = req_valid && req_op == 3'd3;
  wire cmd_clr_en  = req_valid && req_op == 3'd4;
  wire cmd_clr_chg = req_valid && req_op == 3'd5;
  wire cmd_clr_lp  = req_valid && req_op == 3'd6;

  wire [NPORTS-1:0] hot = {{(NPORTS-1){1'b0}}, 1'b1} << req_port;
  wire [NPORTS-1:0] sel = gang_pwr ? {NPORTS{1'b1}} : hot;

  assign oc_stat = gang_ovc ? {NPORTS{|oc_flt}} : oc_flt;
  wire [NPORTS-1:0] trip = gang_pwr ? {NPORTS{|oc_stat}} : oc_stat;

  wire [NPORTS-1:0] sw_nxt = ~trip & ((sw_q & ~({NPORTS{cmd_clr_pwr}} & sel))
                                     | ({NPORTS{cmd_set_pwr}} & sel));
  wire [NPORTS-1:0] pen_nxt = unsw ? {NPORTS{1'b1}} : sw_nxt;
  wire [NPORTS-1:0] en_nxt = pen_nxt & ((en_q & ~({NPORTS{cmd_clr_en}} & hot))
                                       | ({NPORTS{cmd_set_en}} & hot));
  wire [NPORTS-1:0] chg_nxt = (oc_stat ^ oc_prev)
                            | (chg_q & ~({NPORTS{cmd_clr_chg}} & hot));

  for (genvar i = 0; i < NPORTS; i++) begin : g_deb
    logic          flt_r;
    logic [CW-1:0] cnt_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt_r <= 1'b0;
        cnt_r <= '0;
      end else if (oc_s2[i] == flt_r) begin
        cnt_r <= '0;
      end else if (tick_ms) begin
        if (cnt_r == LAST) begin
          flt_r <= oc_s2[i];
          cnt_r <= '0;
        end else begin
          cnt_r <= cnt_r + 1'b1;
        end
      end
    end
    assign oc_flt[i] = flt_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_s1   <= '0;
      oc_s2   <= '0;
      oc_prev <= '0;
      sw_q    <= '0;
      pwr_q   <= '0;
      en_q    <= '0;
      chg_q   <= '0;
      lp_s1   <= 1'b0;
      lp_s2   <= 1'b0;
      lp_q    <= 1'b0;
      lpc_q   <= 1'b0;
    end else begin
      oc_s1   <= oc_in;
      oc_s2   <= oc_s1;
      oc_prev <= oc_stat;
      sw_q    <= sw_nxt;
      pwr_q   <= pen_nxt;
      en_q    <= en_nxt;
      chg_q   <= chg_nxt;
      lp_s1   <= local_good;
      lp_s2   <= lp_s1;
      lp_q    <= self_pwr & lp_s2;
      lpc_q   <= (self_pwr & (lp_s2 ^ lp_q)) | (lpc_q & ~cmd_clr_lp);
    end
  end

  assign pwr_en    = pwr_q;
  assign conn_stat = en_q;
  assign oc_chg    = chg_q;
  assign lp_stat   = lp_q;
  assign lp_chg    = lpc_q;
endmodule

// File: rtl/hub_port_power_chk.sv
module hub_port_power_chk #(
  parameter int NPORTS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      self_pwr,
  input logic                      pwr_switched,
  input logic                      gang_ovc,
  input logic                      req_valid,
  input logic [2:0]                req_op,
  input logic [$clog2(NPORTS)-1:0] req_port,
  input logic [NPORTS-1:0]         pwr_en,
  input logic [NPORTS-1:0]         conn_stat,
  input logic [NPORTS-1:0]         oc_stat,
  input logic [NPORTS-1:0]         oc_chg,
  input logic                      lp_stat,
  input logic                      lp_chg
);
  localparam int PW = $clog2(NPORTS);

  p_conn_needs_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_stat & ~pwr_en) == '0)
    else $error("conn_stat without power");

  p_fault_cuts_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(self_pwr && !pwr_switched) && oc_stat != '0) |=> ((pwr_en & $past(oc_stat)) == '0))
    else $error("power kept on a faulted port");

  p_unswitched_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (self_pwr && !pwr_switched) |=> (pwr_en == {NPORTS{1'b1}}))
    else $error("unswitched port not powered");

  p_gang_all_or_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gang_ovc |-> (oc_stat == '0 || oc_stat == {NPORTS{1'b1}}))
    else $error("ganged status split");

  p_bus_lp_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !self_pwr |=> !lp_stat)
    else $error("local status reported in bus mode");

  p_bus_lp_no_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!self_pwr && !lp_chg) |=> !lp_chg)
    else $error("local change set in bus mode");

  for (genvar k = 0; k < NPORTS; k++) begin : g_sticky
    p_chg_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_chg[k] && !(req_valid && req_op == 3'd5 && req_port == PW'(k))) |=> oc_chg[k])
      else $error("change bit lost without clear");
  end
endmodule

bind hub_port_power hub_port_power_chk #(.NPORTS(NPORTS)) u_chk (.*);

// File: tb/hub_port_power_test.sv
module hub_port_power_test;
  localparam int N   = 4;
  localparam int DEB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic self_pwr = 1'b0, pwr_switched = 1'b1, gang_pwr = 1'b0, gang_ovc = 1'b0;
  logic local_good = 1'b0;
  logic [N-1:0] oc_in = '0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_port = '0;
  logic [N-1:0] pwr_en, conn_stat, oc_stat, oc_chg;
  logic lp_stat, lp_chg;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  hub_port_power #(.NPORTS(N), .DEB_TICKS(DEB)) uut (.*);

  always #4 clk = ~clk;

  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      tick_ms = (n % 4 == 0);
      n++;
    end
  end

  bit [N-1:0] m_s1, m_s2, m_f, m_prev, m_sw, m_pen, m_en, m_chg;
  int m_cnt [N];
  bit m_l1, m_l2, m_lp, m_lpc;

  always @(posedge clk) begin
    bit anyf, anyo, trip, tgt, hot;
    bit [N-1:0] oce;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_f = '0; m_prev = '0; m_sw = '0;
      m_pen = '0; m_en = '0; m_chg = '0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
      m_l1 = 0; m_l2 = 0; m_lp = 0; m_lpc = 0;
    end else begin
      anyf = |m_f;
      for (int i = 0; i < N; i++) oce[i] = gang_ovc ? anyf : m_f[i];
      anyo = |oce;
      for (int i = 0; i < N; i++) begin
        trip = gang_pwr ? anyo : oce[i];
        tgt  = gang_pwr || (req_port == i);
        hot  = (req_port == i);
        if (trip) m_sw[i] = 0;
        else if (req_valid && req_op == 1 && tgt) m_sw[i] = 1;
        else if (req_valid && req_op == 2 && tgt) m_sw[i] = 0;
        m_pen[i] = (self_pwr && !pwr_switched) ? 1'b1 : m_sw[i];
        if (!m_pen[i]) m_en[i] = 0;
        else if (req_valid && req_op == 3 && hot) m_en[i] = 1;
        else if (req_valid && req_op == 4 && hot) m_en[i] = 0;
        if (oce[i] != m_prev[i]) m_chg[i] = 1;
        else if (req_valid && req_op == 5 && hot) m_chg[i] = 0;
        m_prev[i] = oce[i];
        if (m_s2[i] == m_f[i]) m_cnt[i] = 0;
        else if (tick_ms) begin
          if (m_cnt[i] == DEB - 1) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end
        m_s2[i] = m_s1[i];
        m_s1[i] = oc_in[i];
      end
      if (self_pwr && m_l2 != m_lp) m_lpc = 1;
      else if (req_valid && req_op == 6) m_lpc = 0;
      m_lp = self_pwr ? m_l2 : 1'b0;
      m_l2 = m_l1;
      m_l1 = local_good;
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!done) begin
        chk("R3 pwr_en model", pwr_en, m_pen);
        chk("R5 conn_stat model", conn_stat, m_en);
        chk("R2 oc_stat model", oc_stat, gang_ovc ? {N{|m_f}} : m_f);
        chk("R4 oc_chg model", oc_chg, m_chg);
        chk("R9 lp_stat model", {3'b0, lp_stat}, {3'b0, m_lp});
        chk("R9 lp_chg model", {3'b0, lp_chg}, {3'b0, m_lpc});
      end
    end
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic cmd(int op, int port);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_port = 2'(port);
    @(negedge clk);
    req_valid = 1'b0; req_op = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1'b1;
    summary();
  end

  initial begin
    cyc(3);
    chk("R1 reset pwr_en", pwr_en, '0);
    chk("R1 reset conn_stat", conn_stat, '0);
    chk("R1 reset oc_chg", oc_chg, '0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after release", {pwr_en | conn_stat | oc_stat | oc_chg}, '0);

    for (int p = 0; p < N; p++) cmd(1, p);
    cmd(3, 0); cmd(3, 1);
    cyc(1);
    chk("R7 per-port power", pwr_en, 4'b1111);
    chk("R5 enabled ports", conn_stat, 4'b0011);
    cmd(7, 1); cmd(0, 1);
    chk("R7 unused ops", {pwr_en ^ 4'b1111} | {conn_stat ^ 4'b0011}, '0);

    oc_in[1] = 1'b1; cyc(10); oc_in[1] = 1'b0; cyc(50);
    chk("R2 short pulse ignored", oc_stat | oc_chg, '0);
    chk("R2 short pulse power", pwr_en, 4'b1111);

    oc_in[1] = 1'b1; cyc(60);
    chk("R2 long fault status", oc_stat, 4'b0010);
    chk("R3 fault removes power", pwr_en, 4'b1101);
    chk("R5 fault disables", conn_stat, 4'b0001);
    chk("R4 change set", oc_chg, 4'b0010);
    cmd(1, 1); cyc(1);
    chk("R3 set refused under fault", pwr_en, 4'b1101);
    cmd(3, 1); cyc(1);
    chk("R5 enable refused unpowered", conn_stat, 4'b0001);
    oc_in[1] = 1'b0; cyc(60);
    chk("R3 stays off after release", pwr_en, 4'b1101);
    chk("R4 change still set", oc_chg, 4'b0010);
    cmd(5, 2); cyc(1);
    chk("R4 clear other port", oc_chg, 4'b0010);
    cmd(5, 1); cyc(1);
    chk("R4 clear addressed port", oc_chg, 4'b0000);
    cmd(1, 1); cmd(3, 1); cyc(1);
    chk("R3 repowered", pwr_en, 4'b1111);
    cmd(2, 0); cyc(1);
    chk("R5 power off disables", conn_stat, 4'b0010);

    gang_ovc = 1'b1;
    cmd(1, 0); cmd(3, 0);
    oc_in[2] = 1'b1; cyc(60);
    chk("R6 gang status", oc_stat, 4'b1111);
    chk("R6 gang power off", pwr_en, 4'b0000);
    chk("R6 gang change", oc_chg, 4'b1111);
    oc_in[2] = 1'b0; cyc(60);
    for (int p = 0; p < N; p++) cmd(5, p);
    gang_ovc = 1'b0;
    cyc(2);

    gang_pwr = 1'b1;
    cmd(1, 3); cyc(1);
    chk("R7 gang set", pwr_en, 4'b1111);
    cmd(3, 2);
    cmd(2, 0); cyc(1);
    chk("R7 gang clear", pwr_en | conn_stat, 4'b0000);
    cmd(1, 0);
    oc_in[0] = 1'b1; cyc(60);
    chk("R7 gang fault all off", pwr_en, 4'b0000);
    oc_in[0] = 1'b0; cyc(60);
    cmd(5, 0);
    gang_pwr = 1'b0;

    self_pwr = 1'b1; pwr_switched = 1'b0;
    cyc(2);
    chk("R8 unswitched all on", pwr_en, 4'b1111);
    oc_in[3] = 1'b1; cyc(60);
    chk("R8 unswitched ignores fault", pwr_en, 4'b1111);
    oc_in[3] = 1'b0; cyc(60);
    cmd(5, 3);

    local_good = 1'b1; cyc(6);
    chk("R9 self lp_stat", {3'b0, lp_stat}, 4'b0001);
    chk("R9 self lp_chg", {3'b0, lp_chg}, 4'b0001);
    cmd(6, 0); cyc(1);
    chk("R9 lp_chg cleared", {3'b0, lp_chg}, 4'b0000);
    pwr_switched = 1'b1;
    self_pwr = 1'b0;
    cyc(2);
    local_good = 1'b0; cyc(4); local_good = 1'b1; cyc(6);
    chk("R9 bus lp ignored", {2'b0, lp_stat, lp_chg}, 4'b0000);

    cyc(5);
    done = 1'b1;
    summary();
  end
endmodule